// File: doc/BRIEF.md
# Integer ALU with Immediate Operand Preparation

This block is the combinational arithmetic and logic unit of a 32-bit integer execution stage. It takes two register operands and a 16-bit instruction immediate, prepares the second operand (register value, sign-extended immediate or zero-extended immediate), and performs one of eleven decoded operations: wrapping or overflow-checked addition and subtraction, four bitwise operations, signed and unsigned set-less-than, and load-upper-immediate.

Besides the result it produces a zero flag, which the branch unit uses for equality tests, and an overflow flag. The overflow flag is raised only for the overflow-checked forms of addition and subtraction. Taking a trap on it is left to the surrounding pipeline. There is no clock and no state: every output follows its inputs within the same cycle.

Top module: `int_alu`

## Requirements
- R1: With op_sel 0 (checked add) or 1 (wrapping add), result equals operand A plus the prepared B, modulo 2^32.
- R2: With op_sel 2 (checked subtract) or 3 (wrapping subtract), result equals A minus the prepared B, modulo 2^32.
- R3: alu_ovf is 1 only when op_sel is 0 or 2 and the true signed sum or difference lies outside the signed 32-bit range; for every other op_sel it is 0.
- R4: op_sel 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR of A and the prepared B.
- R5: op_sel 8 gives 1 when A is less than the prepared B as signed two's complement numbers and 0 otherwise, including when A minus B overflows.
- R6: op_sel 9 gives 1 when A is less than the prepared B as unsigned numbers and 0 otherwise.
- R7: When use_imm is 1, the prepared B is the immediate zero-extended for op_sel 4 to 7 and sign-extended from bit 15 for op_sel 0 to 3, 8 and 9; when use_imm is 0 it is opnd_b.
- R8: op_sel 10 gives the immediate in bits 31:16 and zeros in bits 15:0, whatever A, B and use_imm are.
- R9: alu_zero is 1 exactly when result is all zeros.
- R10: The unused codes op_sel 11 to 15 give result 0, alu_ovf 0 and alu_zero 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand from the register file |
| imm | input | 16 | Instruction immediate |
| use_imm | input | 1 | Take the second operand from the immediate |
| op_sel | input | 4 | Decoded operation code |
| result | output | 32 | Operation result |
| alu_zero | output | 1 | Result is zero |
| alu_ovf | output | 1 | Signed overflow on a checked add or subtract |

## Verification
The embedded assertions are immediate checks that take for granted that every input holds a known value; each is guarded against unknowns, and the bench drives only defined values on every port from the first cycle. They also assume that the inputs have settled, so the bench changes inputs only at a rising edge and reads the outputs at the following falling edge. All sixteen op_sel codes, the unused ones included, are swept over a set of operand corners: sign boundaries, all ones, and values whose halves differ. The immediate extension is swept separately with immediates on either side of bit 15.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_LUI  = 4'd10
  } alu_op_e;

  // Bitwise group selector handed to the logic unit
  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;

  function automatic logic op_is_logical(input logic [3:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  endfunction

  function automatic logic op_is_checked(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic op_uses_subtract(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  // Sign rule: operands of equal sign giving a result of the other sign
  function automatic logic sign_overflow(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // Signed less-than from the operand signs and the difference sign
  function automatic logic signed_less(input logic sa, input logic sb, input logic sd);
    return (sa != sb) ? sa : sd;
  endfunction

endpackage

// File: rtl/int_alu_imm_prep.sv
module int_alu_imm_prep #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              zero_ext,
  output logic [DATA_W-1:0] b_eff
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic              fill_bit;

  assign fill_bit = zero_ext ? 1'b0 : imm[IMM_W-1];

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{fill_bit}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign b_eff = use_imm ? imm_ext : reg_b;

  always_comb begin
    if (!$isunknown({use_imm, zero_ext, imm}) && use_imm && PAD_W > 0) begin
      // R7: upper bits are all copies of the fill (zero or immediate sign)
      a_r7_ext_fill: assert (b_eff[DATA_W-1] == (zero_ext ? 1'b0 : imm[IMM_W-1]) &&
                             b_eff[IMM_W-1:0] == imm[IMM_W-1:0]);
    end
  end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              do_sub,
  input  logic              check_en,
  input  logic              cmp_unsigned,
  output logic [DATA_W-1:0] sum,
  output logic              ovf,
  output logic              less
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_op;
  logic [DATA_W:0]   wide;
  logic              carry_out;
  logic              ovf_raw;
  logic              less_s;
  logic              less_u;

  assign b_op      = do_sub ? ~b : b;
  assign wide      = {1'b0, a} + {1'b0, b_op} + {{DATA_W{1'b0}}, do_sub};
  assign sum       = wide[DATA_W-1:0];
  assign carry_out = wide[DATA_W];

  assign ovf_raw = sign_overflow(a[MSB], b_op[MSB], sum[MSB]);
  assign ovf     = check_en & ovf_raw;

  // Signed compare does not trust the possibly overflowed difference sign alone
  assign less_s = signed_less(a[MSB], b[MSB], sum[MSB]);
  // No carry out of A + ~B + 1 means a borrow, so A < B unsigned
  assign less_u = do_sub & ~carry_out;
  assign less   = cmp_unsigned ? less_u : less_s;

  always_comb begin
    if (!$isunknown({a, b, do_sub, cmp_unsigned}) && do_sub && (a == b)) begin
      // R5, R6: equal operands are never less and never overflow
      a_r5_equal_not_less: assert (!less && !ovf_raw);
    end
    if (!$isunknown({a, b, do_sub, cmp_unsigned}) && do_sub && cmp_unsigned &&
        (a[MSB] != b[MSB])) begin
      // R6: with differing top bits the one with top bit clear is smaller
      a_r6_unsigned_split: assert (less == b[MSB]);
    end
  end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic_sel_e        sel,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

  always_comb begin
    if (!$isunknown({a, b, sel}) && sel == LG_AND) begin
      // R4: an AND result never sets a bit that either operand lacks
      a_r4_and_subset: assert ((y & ~a) == '0 && (y & ~b) == '0);
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic [3:0]        op_sel,
  output logic [DATA_W-1:0] result,
  output logic              alu_zero,
  output logic              alu_ovf
);
  localparam int LOW_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] arith_sum;
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] upper_imm;
  logic              arith_ovf;
  logic              arith_less;
  logic              zero_ext;
  logic              do_sub;
  logic              check_en;
  logic              cmp_unsigned;
  logic_sel_e        lg_sel;

  // Decode: each is a named wire so checks can see the internal events
  assign zero_ext     = op_is_logical(op_sel);
  assign do_sub       = op_uses_subtract(op_sel);
  assign check_en     = op_is_checked(op_sel);
  assign cmp_unsigned = (op_sel == OP_SLTU);
  assign lg_sel       = logic_sel_e'(op_sel[1:0]);

  int_alu_imm_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
    .reg_b    (opnd_b),
    .imm      (imm),
    .use_imm  (use_imm),
    .zero_ext (zero_ext),
    .b_eff    (b_eff)
  );

  int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a            (opnd_a),
    .b            (b_eff),
    .do_sub       (do_sub),
    .check_en     (check_en),
    .cmp_unsigned (cmp_unsigned),
    .sum          (arith_sum),
    .ovf          (arith_ovf),
    .less         (arith_less)
  );

  int_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a   (opnd_a),
    .b   (b_eff),
    .sel (lg_sel),
    .y   (logic_y)
  );

  generate
    if (LOW_W > 0) begin : g_lui_pad
      assign upper_imm = {imm, {LOW_W{1'b0}}};
    end else begin : g_lui_trunc
      assign upper_imm = imm[IMM_W-1 -: DATA_W];
    end
  endgenerate

  always_comb begin
    case (op_sel)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = arith_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result = logic_y;
      OP_SLT, OP_SLTU:                  result = {{(DATA_W-1){1'b0}}, arith_less};
      OP_LUI:                           result = upper_imm;
      default:                          result = '0;
    endcase
  end

  assign alu_zero = (result == '0);
  assign alu_ovf  = arith_ovf;

  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b, imm, use_imm})) begin
      // R3: overflow only ever leaves the block for the checked add and subtract
      a_r3_no_overflow: assert (!alu_ovf || op_sel == OP_ADD || op_sel == OP_SUB);
      if (op_sel == OP_LUI && LOW_W > 0) begin
        // R8: the low half of a load-upper result is clear
        a_r8_lui_low_clear: assert (result[LOW_W-1:0] == '0);
      end
      if (op_sel == OP_SLT || op_sel == OP_SLTU) begin
        // R5, R6: set-less-than yields only 0 or 1
        a_r5_slt_single_bit: assert (result[DATA_W-1:1] == '0);
      end
      if (op_sel > OP_LUI) begin
        // R10: unused codes produce a zero result with the zero flag set
        a_r10_unused_quiet: assert (alu_zero && !alu_ovf);
      end
    end
  end

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int DW = 32;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] opnd_a = '0;
  logic [DW-1:0] opnd_b = '0;
  logic [IW-1:0] imm = '0;
  logic          use_imm = 1'b0;
  logic [3:0]    op_sel = 4'd0;
  logic [DW-1:0] result;
  logic          alu_zero;
  logic          alu_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_alu #(.DATA_W(DW), .IMM_W(IW)) u_int_alu (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .imm      (imm),
    .use_imm  (use_imm),
    .op_sel   (op_sel),
    .result   (result),
    .alu_zero (alu_zero),
    .alu_ovf  (alu_ovf)
  );

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'hFFFF_FFFE;
      6: return 32'h1234_5678;
      7: return 32'h8000_0001;
      8: return 32'h0000_FFFF;
      default: return 32'hFFFF_0000;
    endcase
  endfunction

  function automatic logic [15:0] imm_corner(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'hA5C3;
    endcase
  endfunction

  function automatic string req_tag(input int op, input logic imm_on);
    if (imm_on && op <= 9) return "R7";
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5, 6, 7: return "R4";
      8: return "R5";
      9: return "R6";
      10: return "R8";
      default: return "R10";
    endcase
  endfunction

  // Reference model worked in wide signed integers
  task automatic model(input int op, input logic [31:0] a, input logic [31:0] rb,
                       input logic [15:0] im, input logic imm_on,
                       output logic [31:0] exp_r, output logic exp_v);
    logic [31:0] b;
    longint sa, sb, wide;
    if (!imm_on) b = rb;
    else if (op >= 4 && op <= 7) b = {16'h0000, im};
    else b = {{16{im[15]}}, im};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    exp_v = 1'b0;
    case (op)
      0, 1: begin
        exp_r = a + b;
        wide = sa + sb;
        exp_v = (op == 0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      2, 3: begin
        exp_r = a - b;
        wide = sa - sb;
        exp_v = (op == 2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      4: exp_r = a & b;
      5: exp_r = a | b;
      6: exp_r = a ^ b;
      7: exp_r = ~(a | b);
      8: exp_r = (sa < sb) ? 32'd1 : 32'd0;
      9: exp_r = (a < b) ? 32'd1 : 32'd0;
      10: exp_r = {im, 16'h0000};
      default: exp_r = 32'd0;
    endcase
  endtask

  task automatic apply_and_check(input int op, input logic [31:0] a, input logic [31:0] b,
                                 input logic [15:0] im, input logic imm_on);
    logic [31:0] exp_r;
    logic        exp_v;
    string       tag;
    @(posedge clk);
    op_sel  = op[3:0];
    opnd_a  = a;
    opnd_b  = b;
    imm     = im;
    use_imm = imm_on;
    @(negedge clk);
    model(op, a, b, im, imm_on, exp_r, exp_v);
    tag = req_tag(op, imm_on);
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s result op=%0d a=%h b=%h imm=%h ui=%0d actual=%h expected=%h",
               tag, op, a, b, im, imm_on, result, exp_r);
    end
    checks++;
    if (alu_ovf !== exp_v) begin
      errors++;
      $display("FAIL R3 overflow op=%0d a=%h b=%h imm=%h ui=%0d actual=%0d expected=%0d",
               op, a, b, im, imm_on, alu_ovf, exp_v);
    end
    checks++;
    if (alu_zero !== (exp_r == 32'd0)) begin
      errors++;
      $display("FAIL R9 zero op=%0d a=%h b=%h actual=%0d expected=%0d",
               op, a, b, alu_zero, (exp_r == 32'd0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Quiescent state: all-zero inputs give a zero add with the flag set (R1, R9)
    @(negedge clk);
    checks++;
    if (result !== 32'd0 || alu_zero !== 1'b1 || alu_ovf !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle actual=%h/%0d/%0d expected=00000000/1/0",
               result, alu_zero, alu_ovf);
    end
    // Register operand sweep over every code, unused ones included
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          apply_and_check(op, corner(i), corner(j), 16'h5A5A, 1'b0);
    // Immediate operand sweep: opnd_b carries a decoy that must not be used (R7)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 10; i++)
        for (int k = 0; k < 6; k++)
          apply_and_check(op, corner(i), 32'hDEAD_BEEF, imm_corner(k), 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule